// File: doc/BRIEF.md
# Port Input Interrupt Flag Controller

This block watches sixteen general-purpose input lines and turns their activity into interrupt requests. Each line has four settings of its own: a trigger-mode bit that picks edge or level detection, a polarity bit that picks which edge or level counts as active, a sticky interrupt flag, and an enable mask bit. The flagged and enabled lines are ORed into one interrupt request for the interrupt controller. A wake request, suited to a power manager, fires as soon as an enabled line triggers.

A 4-bit selector routes the trigger event of one line to a DMA request output. That output ignores the mask, so a line can pace DMA transfers while its interrupt stays disabled.

Software reaches the settings through a small register port that has a one-cycle registered read. Flags are cleared by writing ones. Each input passes through a two-flop synchronizer before detection.

Top module: `pint_unit`

## Requirements
- R1: After synchronous reset, `irq_o`, `wake_o`, `dma_o` and `rdata_o` are 0, every flag is 0 and every mask bit is 0.
- R2: The mode register (address 0) resets to all ones. Bit i = 1 makes line i edge-triggered and bit i = 0 makes it level-triggered. In edge mode a held input sets the flag only once per active edge.
- R3: The polarity register (address 1) resets to all ones. Bit i = 1 selects a rising edge or high level for line i, and 0 selects a falling edge or low level.
- R4: The flag of line i (flag register, address 2, bit i) sets on a trigger event and stays 1 until software clears it, even after the input returns to its inactive state.
- R5: Writing 1 to bit i of address 2 clears flag i, and writing 0 leaves it unchanged. If a trigger event for that line occurs in the same cycle as the clear, the flag stays 1. A level-mode line whose input is still active therefore sets its flag again.
- R6: `irq_o` is 1 in the cycle after any line has both its flag and its mask bit (address 3, bit i) at 1, and is 0 in the cycle after no line does.
- R7: The DMA select field (address 4, bits 3:0, reset 0) names the source line by its index. `dma_o` pulses for exactly one cycle when that line's trigger condition becomes true, whatever its mask bit is.
- R8: `wake_o` is 1 in the cycle after an enabled line triggers or holds an enabled flag, in either trigger mode. It is always 1 whenever `irq_o` is 1.
- R9: A pin change reaches the flag three clock edges after it is sampled: two synchronizer stages, then the flag register. `irq_o` follows one edge later.
- R10: A read with `rd_en_i` returns the addressed register on `rdata_o` after the next edge, zero-extended. Unused addresses 5 to 7 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 16 | Asynchronous input lines |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt request |
| wake_o | output | 1 | Sleep wake request |
| dma_o | output | 1 | Single-cycle DMA trigger pulse |

## Verification
The assertions assume that the lines are inactive while reset is held, because the synchronizer and edge history reset to 0. A line that is high at reset looks like a rising edge on the first cycle after reset. The stimulus holds every pin low during reset and changes pins only at the inactive clock edge. Within that limit, random pin values, modes, polarities, masks and DMA selections may change on any cycle. Writes also land on unused addresses, so the ignore rule is exercised.

// File: rtl/pint_pkg.sv
package pint_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_MODE = 3'd0,
    REG_POL  = 3'd1,
    REG_FLAG = 3'd2,
    REG_MASK = 3'd3,
    REG_DSEL = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/pint_sync.sv
module pint_sync #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] sync_o
);
  logic [N-1:0] meta_q;
  logic [N-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/pint_detect.sv
module pint_detect #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] sync_i,
  input  logic [N-1:0] mode_i,
  input  logic [N-1:0] pol_i,
  output logic [N-1:0] trig_o
);
  logic [N-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst) hist_q <= '0;
    else     hist_q <= sync_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_line
    logic rise, fall, lvl;
    assign rise = sync_i[i] & ~hist_q[i];
    assign fall = ~sync_i[i] & hist_q[i];
    assign lvl  = (sync_i[i] == pol_i[i]);
    assign trig_o[i] = mode_i[i] ? (pol_i[i] ? rise : fall) : lvl;

    // Edge mode: one event per edge while settings hold still.
    assert_edge_once_R2: assert property (@(posedge clk) disable iff (rst)
      (trig_o[i] && mode_i[i]) |=>
        (!trig_o[i] || !$stable(mode_i[i]) || !$stable(pol_i[i])));
  end
endmodule

// File: rtl/pint_flags.sv
module pint_flags #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] trig_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;

  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= (flag_q & ~clr_i) | trig_i;
  end

  assign flag_o = flag_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (rst)
      (flag_q[i] && !clr_i[i]) |=> flag_q[i]);
    assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
      trig_i[i] |=> flag_q[i]);
    assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
      (clr_i[i] && !trig_i[i]) |=> !flag_q[i]);
  end
endmodule

// File: rtl/pint_regs.sv
module pint_regs
  import pint_pkg::*;
#(
  parameter int N      = 16,
  parameter int DATA_W = 32,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N-1:0]      flag_i,
  output logic [N-1:0]      mode_o,
  output logic [N-1:0]      pol_o,
  output logic [N-1:0]      mask_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [N-1:0]      clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [N-1:0]      mode_q, pol_q, mask_q;
  logic [SEL_W-1:0]  sel_q;
  logic [DATA_W-1:0] rmux;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '1;
      pol_q  <= '1;
      mask_q <= '0;
      sel_q  <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        REG_MODE: mode_q <= wdata_i[N-1:0];
        REG_POL:  pol_q  <= wdata_i[N-1:0];
        REG_MASK: mask_q <= wdata_i[N-1:0];
        REG_DSEL: sel_q  <= wdata_i[SEL_W-1:0];
        default:  ;
      endcase
    end
  end

  assign clr_o = (wr_en_i && addr_i == REG_FLAG) ? wdata_i[N-1:0] : '0;

  always_comb begin
    rmux = '0;
    case (addr_i)
      REG_MODE: rmux[N-1:0]     = mode_q;
      REG_POL:  rmux[N-1:0]     = pol_q;
      REG_FLAG: rmux[N-1:0]     = flag_i;
      REG_MASK: rmux[N-1:0]     = mask_q;
      REG_DSEL: rmux[SEL_W-1:0] = sel_q;
      default:  rmux            = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rmux;
  end

  assign mode_o  = mode_q;
  assign pol_o   = pol_q;
  assign mask_o  = mask_q;
  assign sel_o   = sel_q;
  assign rdata_o = rdata_q;

  assert_unused_wr_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i > REG_DSEL) |=>
      ($stable(mode_q) && $stable(pol_q) && $stable(mask_q) && $stable(sel_q)));
endmodule

// File: rtl/pint_unit.sv
module pint_unit
  import pint_pkg::*;
#(
  parameter int N      = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      pin_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              wake_o,
  output logic              dma_o
);
  localparam int SEL_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]     sync, trig, trig_q, flag, mode, pol, mask, clr;
  logic [SEL_W-1:0] sel;
  logic             irq_q, wake_q, dma_q;

  pint_sync #(.N(N)) u_sync (
    .clk(clk), .rst(rst), .pin_i(pin_i), .sync_o(sync));

  pint_detect #(.N(N)) u_det (
    .clk(clk), .rst(rst), .sync_i(sync), .mode_i(mode), .pol_i(pol),
    .trig_o(trig));

  pint_flags #(.N(N)) u_flags (
    .clk(clk), .rst(rst), .trig_i(trig), .clr_i(clr), .flag_o(flag));

  pint_regs #(.N(N), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .flag_i(flag), .mode_o(mode),
    .pol_o(pol), .mask_o(mask), .sel_o(sel), .clr_o(clr), .rdata_o(rdata_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q <= '0;
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
      dma_q  <= 1'b0;
    end else begin
      trig_q <= trig;
      irq_q  <= |(flag & mask);
      wake_q <= |((flag | trig) & mask);
      dma_q  <= trig[sel] & ~trig_q[sel];
    end
  end

  assign irq_o  = irq_q;
  assign wake_o = wake_q;
  assign dma_o  = dma_q;

  assert_irq_set_R6: assert property (@(posedge clk) disable iff (rst)
    (|(flag & mask)) |=> irq_o);
  assert_irq_clr_R6: assert property (@(posedge clk) disable iff (rst)
    !(|(flag & mask)) |=> !irq_o);
  assert_wake_cover_R8: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> wake_o);
  assert_dma_source_R7: assert property (@(posedge clk) disable iff (rst)
    dma_o |-> $past(|trig));
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!irq_o && !wake_o && !dma_o));
endmodule

// File: tb/tb_pint_unit.sv
`timescale 1ns/1ps
module tb_pint_unit;
  localparam int N = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  pin;
  logic          we, re;
  logic [2:0]    addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          irq, wake, dma;

  int n_chk = 0;
  int n_bad = 0;

  // reference state
  logic [N-1:0] m_s1, m_s2, m_prev, m_flag, m_mode, m_pol, m_mask, m_tq;
  logic [3:0]   m_sel;
  logic         m_irq, m_wake, m_dma;
  logic [DW-1:0] m_rd;

  always #10 clk = ~clk;

  pint_unit #(.N(N), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .pin_i(pin), .wr_en_i(we), .rd_en_i(re),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .wake_o(wake), .dma_o(dma));

  function automatic logic [N-1:0] f_trig(logic [N-1:0] s, logic [N-1:0] p,
                                          logic [N-1:0] md, logic [N-1:0] pl);
    logic [N-1:0] t;
    for (int i = 0; i < N; i++) begin
      if (md[i]) t[i] = pl[i] ? (s[i] & ~p[i]) : (~s[i] & p[i]);
      else       t[i] = (s[i] == pl[i]);
    end
    return t;
  endfunction

  function automatic logic [DW-1:0] f_read(logic [2:0] a);
    logic [DW-1:0] v = '0;
    case (a)
      3'd0: v[N-1:0] = m_mode;
      3'd1: v[N-1:0] = m_pol;
      3'd2: v[N-1:0] = m_flag;
      3'd3: v[N-1:0] = m_mask;
      3'd4: v[3:0]   = m_sel;
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_s1 = '0; m_s2 = '0; m_prev = '0; m_flag = '0; m_tq = '0;
    m_mode = '1; m_pol = '1; m_mask = '0; m_sel = '0;
    m_irq = 0; m_wake = 0; m_dma = 0; m_rd = '0;
  endtask

  // one clock cycle with the given inputs; model tracks the DUT
  task automatic cyc(input logic [N-1:0] p, input logic w, input logic [2:0] a,
                     input logic [DW-1:0] d, input logic r);
    logic [N-1:0] t, clr;
    @(negedge clk);
    pin = p; we = w; addr = a; wdata = d; re = r;
    t   = f_trig(m_s2, m_prev, m_mode, m_pol);
    clr = (w && a == 3'd2) ? d[N-1:0] : '0;
    @(posedge clk);
    #1;
    if (r) m_rd = f_read(a);
    m_irq  = |(m_flag & m_mask);
    m_wake = |((m_flag | t) & m_mask);
    m_dma  = t[m_sel] & ~m_tq[m_sel];
    m_tq   = t;
    m_flag = (m_flag & ~clr) | t;
    m_prev = m_s2; m_s2 = m_s1; m_s1 = p;
    if (w) case (a)
      3'd0: m_mode = d[N-1:0];
      3'd1: m_pol  = d[N-1:0];
      3'd3: m_mask = d[N-1:0];
      3'd4: m_sel  = d[3:0];
      default: ;
    endcase
    check("R6 irq", irq, m_irq);
    check("R8 wake", wake, m_wake);
    check("R7 dma", dma, m_dma);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) cyc(pin, 0, 3'd0, '0, 0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    cyc(pin, 1, a, d, 0);
  endtask

  task automatic rd(input logic [2:0] a, input logic [DW-1:0] exp, input string tag);
    cyc(pin, 0, a, '0, 1);
    check(tag, rdata, exp);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int dma_cnt;
    void'($urandom(32'h5eed_1234));
    rst = 1; pin = '0; we = 0; re = 0; addr = '0; wdata = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1 reset state
    check("R1 irq after reset", irq, 0);
    check("R1 rdata after reset", rdata, 0);
    rd(3'd0, 32'h0000_FFFF, "R2 mode reset");
    rd(3'd1, 32'h0000_FFFF, "R3 polarity reset");
    rd(3'd2, 32'h0, "R1 flags reset");
    rd(3'd3, 32'h0, "R1 mask reset");
    rd(3'd4, 32'h0, "R7 select reset");

    // R9 / R4 rising edge on line 3: flag visible after three edges
    cyc(16'h0008, 0, 3'd0, '0, 0);
    cyc(16'h0008, 0, 3'd0, '0, 0);
    rd(3'd2, 32'h0, "R9 not yet flagged");
    rd(3'd2, 32'h8, "R9 flag after three edges");
    cyc(16'h0000, 0, 3'd0, '0, 0);
    idle(4);
    rd(3'd2, 32'h8, "R4 flag sticky");

    // R5 write-one-to-clear
    wr(3'd2, 32'h0);
    rd(3'd2, 32'h8, "R5 write 0 no effect");
    wr(3'd2, 32'h8);
    rd(3'd2, 32'h0, "R5 write 1 clears");

    // R3 falling edge on line 1
    wr(3'd1, 32'hFFFD);
    cyc(16'h0002, 0, 3'd0, '0, 0); idle(4);
    rd(3'd2, 32'h0, "R3 rising ignored when falling selected");
    cyc(16'h0000, 0, 3'd0, '0, 0); idle(3);
    rd(3'd2, 32'h2, "R3 falling edge sets");
    wr(3'd2, 32'h2);
    wr(3'd1, 32'hFFFF);

    // R2/R5 level-low on line 5, re-sets while active
    wr(3'd0, 32'hFFDF);
    wr(3'd1, 32'hFFDF);
    idle(2);
    wr(3'd2, 32'h20);
    rd(3'd2, 32'h20, "R5 level re-sets after clear");
    cyc(16'h0020, 0, 3'd0, '0, 0); idle(3);
    wr(3'd2, 32'h20);
    rd(3'd2, 32'h0, "R2 level inactive stays clear");
    wr(3'd0, 32'hFFFF); wr(3'd1, 32'hFFFF);

    // R6 mask gates interrupt
    wr(3'd3, 32'h0001);
    cyc(16'h0021, 0, 3'd0, '0, 0); idle(4);
    check("R6 irq with enabled flag", irq, 1);
    check("R8 wake with enabled flag", wake, 1);
    wr(3'd2, 32'h1);
    idle(1);
    check("R6 irq drops after clear", irq, 0);

    // R7 DMA from masked line 9
    wr(3'd3, 32'h0);
    wr(3'd4, 32'h9);
    dma_cnt = 0;
    for (int i = 0; i < 8; i++) begin
      cyc(16'h0221, 0, 3'd0, '0, 0);
      if (dma) dma_cnt++;
    end
    check("R7 one pulse while masked", dma_cnt, 1);
    check("R7 masked irq stays low", irq, 0);

    // R10 unused address
    wr(3'd6, 32'h0);
    rd(3'd6, 32'h0, "R10 unused reads zero");
    rd(3'd3, 32'h0, "R10 unused write ignored");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] p;
      logic w, r;
      logic [2:0] a;
      logic [DW-1:0] d;
      p = ($urandom % 4 == 0) ? N'($urandom) : pin;
      w = ($urandom % 5 == 0);
      r = ($urandom % 3 == 0);
      a = 3'($urandom % 8);
      d = $urandom;
      cyc(p, w, a, d, r);
      if (r) check("R10 random read", rdata, m_rd);
    end

    summary();
  end
endmodule